// File: doc/BRIEF.md
# Two-Phase Counting Barrier

This block holds a group of requesters, such as cores or hardware threads, at a common synchronization point. A requester raises its arrive line and keeps it high. The unit admits waiting requesters one per clock and counts them. When the count reaches the configured participant total, the unit stops admitting. It then lets the held requesters go one per clock and gives each a single-cycle release pulse. Once the count has fallen back to zero, admission resumes.

Two gates work against each other. Only one of them is open at any time, and a single counter rises on entry and falls on exit. Because of this, a requester that leaves early and raises its request again at once cannot enter the next episode before the slower members of the current episode have left. A phase bit flips at the end of each episode.

Top module: `sync_barrier`

## Requirements
- R1: During reset and on the first cycle after it, `held_o` is all zero, `release_o` is all zero, `depart_o` is 0 and `phase_o` is 0.
- R2: While `depart_o` is 0, each clock edge admits at most one requester. The admitted one is the lowest-numbered requester whose `arrive_i` bit is 1 and whose `held_o` bit is 0, and its `held_o` bit is set at that edge.
- R3: The edge that raises the number admitted to the participant total also sets `depart_o` to 1. No requester is admitted at that edge after the total is reached.
- R4: While `depart_o` is 1, `arrive_i` is ignored and no `held_o` bit is set.
- R5: While `depart_o` is 1, each edge lets out exactly one requester, the lowest-numbered one with its `held_o` bit set. At that edge its `held_o` bit is cleared, and `release_o` shows that requester's bit alone for one cycle.
- R6: The edge that lets out the last held requester clears `depart_o` and inverts `phase_o`. The next edge can admit again.
- R7: A requester whose `held_o` bit is set is counted only once, however long it keeps `arrive_i` high. `depart_o` is reached only by that many distinct requesters.
- R8: `cfg_total_i` is taken while reset is low and on every edge where the unit is idle (`depart_o` 0 and no requester held). A value of 0 is treated as 1, and a value above NREQ is treated as NREQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_total_i | input | $clog2(NREQ+1) | Participant total for the next episode |
| arrive_i | input | NREQ | Per-requester arrive request, held high until release |
| release_o | output | NREQ | One-cycle release pulse for the requester being let out |
| held_o | output | NREQ | Requesters currently inside the barrier |
| depart_o | output | 1 | 1 while the departure gate is open |
| phase_o | output | 1 | Inverts at the end of each episode |

## Verification
A counter that is off by one shows at the ports within one episode. `depart_o` then rises one admission early or late, or it never falls after the last pulse on `release_o`. A damaged held set shows up in the next admission or departure as a release pulse for the wrong index, a second admission of the same requester, or an entry during the departure phase. The scoreboard compares every release pulse against the expected order, and the bench reads `held_o` after each edge, so these faults are caught within a few cycles of their cause.

// File: rtl/sync_barrier.sv
module sync_barrier #(
  parameter int NREQ = 4,
  localparam int CW = $clog2(NREQ + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cfg_total_i,
  input  logic [NREQ-1:0] arrive_i,
  output logic [NREQ-1:0] release_o,
  output logic [NREQ-1:0] held_o,
  output logic            depart_o,
  output logic            phase_o
);

  logic [CW-1:0]   total_q, cnt_q, cfg_fix, total_eff;
  logic [NREQ-1:0] held_q, rel_q, cand, pick;
  logic            depart_q, phase_q, idle;

  assign cfg_fix   = (cfg_total_i == '0) ? CW'(1) :
                     (cfg_total_i > CW'(NREQ)) ? CW'(NREQ) : cfg_total_i;
  assign idle      = !depart_q && (cnt_q == '0);
  assign total_eff = idle ? cfg_fix : total_q;

  assign cand = depart_q ? held_q : (arrive_i & ~held_q);
  assign pick = cand & (~cand + NREQ'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q  <= cfg_fix;
      cnt_q    <= '0;
      depart_q <= 1'b0;
      phase_q  <= 1'b0;
      held_q   <= '0;
      rel_q    <= '0;
    end else begin
      rel_q <= '0;
      if (idle) total_q <= cfg_fix;
      if (|pick) begin
        if (!depart_q) begin
          held_q <= held_q | pick;
          cnt_q  <= cnt_q + CW'(1);
          if (cnt_q + CW'(1) == total_eff) depart_q <= 1'b1;
        end else begin
          held_q <= held_q & ~pick;
          rel_q  <= pick;
          cnt_q  <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            depart_q <= 1'b0;
            phase_q  <= ~phase_q;
          end
        end
      end
    end
  end

  assign release_o = rel_q;
  assign held_o    = held_q;
  assign depart_o  = depart_q;
  assign phase_o   = phase_q;

endmodule

// File: rtl/sync_barrier_chk.sv
module sync_barrier_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] release_o,
  input logic [NREQ-1:0] held_o,
  input logic            depart_o,
  input logic            phase_o
);

  // R5
  rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_o));

  // R5
  rel_was_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> ($past(depart_o) && ((release_o & ~$past(held_o)) == '0)));

  // R4
  no_entry_in_depart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depart_o |=> ((held_o & ~$past(held_o)) == '0));

  // R2
  one_entry_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !depart_o |=> ($countones(held_o & ~$past(held_o)) <= 1));

  // R6
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(depart_o) |-> (phase_o != $past(phase_o)));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(depart_o) == depart_o |-> $stable(phase_o));

endmodule

bind sync_barrier sync_barrier_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .release_o(release_o), .held_o(held_o),
  .depart_o(depart_o), .phase_o(phase_o)
);

// File: tb/sim_sync_barrier.sv
`timescale 1ns/1ps
module sim_sync_barrier;
  localparam int NREQ = 4;
  localparam int CW = $clog2(NREQ + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg = CW'(3);
  logic [NREQ-1:0] arr = '0;
  logic [NREQ-1:0] rel, held;
  logic depart, phase;

  int runs = 0, fails = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  sync_barrier #(.NREQ(NREQ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_total_i(cfg), .arrive_i(arr),
    .release_o(rel), .held_o(held), .depart_o(depart), .phase_o(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50; i++) begin
      if (!depart && held == '0) return;
      step();
    end
    chk("R6 idle reached", 0, 1);
  endtask

  // monitor: every release pulse is compared against the expected order (R5)
  always @(posedge clk) begin
    #1;
    if (rst_n && rel != '0) begin
      if (exp_q.size() == 0) chk("R5 unexpected release", int'(rel), 0);
      else chk("R5 release order", int'(rel), 1 << exp_q.pop_front());
      arr <= arr & ~rel;
    end
  end

  initial begin
    #(200000 * 4);
    chk("watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 held at reset", int'(held), 0);
    chk("R1 depart at reset", int'(depart), 0);
    rst_n = 1'b1;
    step();
    chk("R1 release after reset", int'(rel), 0);
    chk("R1 phase after reset", int'(phase), 0);

    // episode 1: total 3, requesters 0..2 together
    arr = 4'b0111;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    step();
    chk("R2 first admit lowest", int'(held), 4'b0001);
    step();
    chk("R2 second admit", int'(held), 4'b0011);
    chk("R3 not yet depart", int'(depart), 0);
    step();
    chk("R3 depart at total", int'(held), 4'b0111);
    chk("R3 depart raised", int'(depart), 1);
    arr[3] = 1'b1;
    step();
    chk("R4 late arrival ignored", int'(held), 4'b0110);
    step();
    chk("R4 still ignored", int'(held), 4'b0100);
    step();
    chk("R6 depart cleared", int'(depart), 0);
    chk("R6 phase toggled", int'(phase), 1);
    chk("R6 all left", int'(held), 0);
    step();
    chk("R6 admission resumes", int'(held), 4'b1000);

    // episode 2: 3 then 0,1 join; release order 0,1,3
    arr = arr | 4'b0011;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(3);
    step(2);
    chk("R3 episode 2 depart", int'(depart), 1);
    wait_idle();
    chk("R6 phase back", int'(phase), 0);

    // R7: one requester held for long is counted once
    arr = 4'b0001;
    step(6);
    chk("R7 single held", int'(held), 4'b0001);
    chk("R7 no depart", int'(depart), 0);
    arr = arr | 4'b0110;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    step(2);
    chk("R7 completes with distinct", int'(depart), 1);
    wait_idle();

    // R8: total 0 treated as 1
    cfg = '0;
    step();
    arr = 4'b0100;
    exp_q.push_back(2);
    step();
    chk("R8 zero acts as one", int'(depart), 1);
    wait_idle();

    // R8: total above NREQ clamped to NREQ
    cfg = CW'(7);
    step();
    arr = 4'b1111;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    step(3);
    chk("R8 clamp not early", int'(depart), 0);
    step();
    chk("R8 clamp reaches NREQ", int'(depart), 1);
    wait_idle();
    step(2);
    chk("R5 all releases seen", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule